// File: doc/BRIEF.md
# Protected Serial-Memory Command Decoder

This block sits behind the bit engine of a two-wire serial memory slave. The bit engine finds START and STOP and assembles bytes. This block classifies the first byte after each START. It checks a 4-bit command code and three chip-select bits against strap inputs, and it decides whether the slave acknowledges. It then sends the transaction either to the storage array or to a one-time lock register. That register, once armed, write-protects the lower half of the array for good.

A hardware protect pin overrides the software lock. While the pin is high, no array location may be written and the lock register cannot be armed. For array writes the block keeps the word-address pointer. Its low bits advance within a page and wrap at the page boundary. Each data byte yields a write request, its target address and a permit bit. A refused write is still acknowledged, so the storage side runs its full write time either way. Bit sampling on the wire and the storage itself live elsewhere.

Top module: `cmd_guard_decoder`

## Requirements
- R1: A control byte whose bits 7:4 are 1010 and whose bits 3:1 equal `strap_cs` is acknowledged while `prog_busy` is low. Bit 0 = 1 gives `txn_type` 2 (array read) and bit 0 = 0 gives `txn_type` 1 (array write). The `txn_type` encodings are 0 none, 1 array write, 2 array read, 3 lock write.
- R2: A control byte whose bits 3:1 differ from `strap_cs`, or whose bits 7:4 are neither 1010 nor 0110, is not acknowledged, and `txn_type` becomes 0.
- R3: No control byte is acknowledged while `prog_busy` is high.
- R4: A control byte with code 0110 and bit 0 = 1 (read) is never acknowledged.
- R5: A control byte with code 0110 and bit 0 = 0 is acknowledged (`txn_type` 3) while the lock is clear and `hw_wp` is low. The two bytes after it are acknowledged and their values are ignored. The lock is set at the following STOP, and only if at least two bytes followed the control byte.
- R6: Once the lock is set (`prot_status[0]` = 1), the 0110 write control byte is no longer acknowledged. The lock is never cleared, not even by `rst`. The `lock_preload` input sets it directly.
- R7: While `hw_wp` is high, the 0110 write control byte is not acknowledged and the lock cannot be set. `prot_status[1]` mirrors `hw_wp`.
- R8: In an array write, the first byte after the control byte loads the word-address pointer and is acknowledged. Each later byte is acknowledged and pulses `wr_req` with `wr_addr` equal to the pointer. The pointer then advances only in its low PAGE_W bits, wrapping inside the page.
- R9: `wr_allow` is 0 when `hw_wp` is high, or when the lock is set and the target address has its top bit clear. Otherwise it is 1. The byte is acknowledged in every case.
- R10: After reset `resp_vld`, `wr_req` and `txn_type` are 0. A byte that arrives outside an acknowledged command (before any START, after a refused control byte, or during an array read) gives `resp_vld` with `resp_ack` = 0.
- R11: Each `byte_vld` strobe is answered by a one-cycle `resp_vld` pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not clear the lock) |
| byte_vld | input | 1 | Received-byte strobe from the bit engine |
| byte_data | input | 8 | Received byte |
| start_seen | input | 1 | START (or repeated START) detected |
| stop_seen | input | 1 | STOP detected |
| prog_busy | input | 1 | Internal programming cycle in progress |
| strap_cs | input | 3 | Chip-select strap levels |
| hw_wp | input | 1 | Hardware protect pin; tie low when unused |
| lock_preload | input | 1 | Sets the lock flag to model a previously armed part |
| resp_vld | output | 1 | Response to the last received byte is valid |
| resp_ack | output | 1 | 1 = acknowledge the byte |
| txn_type | output | 2 | Current transaction: 0 none, 1 array write, 2 array read, 3 lock write |
| wr_req | output | 1 | A data byte for the array was accepted |
| wr_allow | output | 1 | The accepted data byte may be stored |
| wr_addr | output | ADDR_W | Target address of the accepted data byte |
| prot_status | output | 2 | {hw_wp, lock flag} |

## Verification
The bench builds the main instance with ADDR_W = 8 and PAGE_W = 2. With a 4-byte page, a burst of five data bytes shows the pointer wrap to the start of its page while the upper address bits stay put. An address width of 8 keeps the protected half at 00h–7Fh, so bytes sent to 7Eh, 7Fh and 80h probe both sides of the lock boundary. A second instance holds `lock_preload` high from power-up and shows that the lock takes effect without any bus command.

// File: rtl/cmd_guard_pkg.sv
package cmd_guard_pkg;

    localparam logic [3:0] CODE_ARRAY = 4'b1010;
    localparam logic [3:0] CODE_LOCK  = 4'b0110;

    typedef enum logic [1:0] {
        TXN_NONE    = 2'd0,
        TXN_ARR_WR  = 2'd1,
        TXN_ARR_RD  = 2'd2,
        TXN_LOCK_WR = 2'd3
    } txn_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_WADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic [3:0] code;
        logic [2:0] cs;
        logic       rd;
    } ctrl_s;

    typedef struct packed {
        logic ack;
        txn_e txn;
    } verdict_s;

    function automatic ctrl_s split_ctrl(input logic [7:0] b);
        return ctrl_s'(b);
    endfunction

endpackage

// File: rtl/cmd_guard_ctrl_decode.sv
module cmd_guard_ctrl_decode
    import cmd_guard_pkg::*;
(
    input  logic [7:0] ctrl_byte,
    input  logic [2:0] strap_cs,
    input  logic       busy,
    input  logic       hw_wp,
    input  logic       locked,
    output verdict_s   verdict
);
    ctrl_s c;

    always_comb begin
        c           = split_ctrl(ctrl_byte);
        verdict.ack = 1'b0;
        verdict.txn = TXN_NONE;
        if (!busy && (c.cs == strap_cs)) begin
            if (c.code == CODE_ARRAY) begin
                verdict.ack = 1'b1;
                verdict.txn = c.rd ? TXN_ARR_RD : TXN_ARR_WR;
            end else if ((c.code == CODE_LOCK) && !c.rd && !locked && !hw_wp) begin
                verdict.ack = 1'b1;
                verdict.txn = TXN_LOCK_WR;
            end
        end
    end
endmodule

// File: rtl/cmd_guard_page_ptr.sv
module cmd_guard_page_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] nxt;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            localparam logic [ADDR_W-1:0] ONE_A = 1;
            assign nxt = ptr_q + ONE_A;
        end else begin : g_paged
            localparam logic [PAGE_W-1:0] ONE_P = 1;
            assign nxt = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + ONE_P};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= '0;
        else if (load) ptr_q <= load_val;
        else if (step) ptr_q <= nxt;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/cmd_guard_lock_flag.sv
module cmd_guard_lock_flag (
    input  logic clk,
    input  logic commit,
    input  logic preload,
    output logic locked
);
    // Models a nonvolatile bit: power-up value only, no reset path.
    logic locked_q = 1'b0;

    always_ff @(posedge clk) begin
        locked_q <= locked_q | commit | preload;
    end

    assign locked = locked_q;
endmodule

// File: rtl/cmd_guard_wr_gate.sv
module cmd_guard_wr_gate (
    input  logic addr_msb,
    input  logic hw_wp,
    input  logic locked,
    output logic allow
);
    always_comb begin
        allow = !hw_wp && !(locked && !addr_msb);
    end
endmodule

// File: rtl/cmd_guard_decoder.sv
module cmd_guard_decoder
    import cmd_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              prog_busy,
    input  logic [2:0]        strap_cs,
    input  logic              hw_wp,
    input  logic              lock_preload,
    output logic              resp_vld,
    output logic              resp_ack,
    output logic [1:0]        txn_type,
    output logic              wr_req,
    output logic              wr_allow,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        prot_status
);
    phase_e            phase_q;
    txn_e              txn_q;
    logic              resp_vld_q, resp_ack_q;
    logic              wr_req_q, wr_allow_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic              lock_data_q;

    verdict_s          verdict;
    logic              locked;
    logic              allow_now;
    logic [ADDR_W-1:0] ptr;
    logic              byte_hit;
    logic              ptr_load, ptr_step;
    logic              commit;
    logic [ADDR_W-1:0] addr_in;

    assign byte_hit = byte_vld && !start_seen && !stop_seen;
    assign ptr_load = byte_hit && (phase_q == PH_WADDR) && (txn_q == TXN_ARR_WR);
    assign ptr_step = byte_hit && (phase_q == PH_DATA)  && (txn_q == TXN_ARR_WR);
    assign commit   = stop_seen && !start_seen && (txn_q == TXN_LOCK_WR)
                      && lock_data_q && !hw_wp;

    generate
        if (ADDR_W >= 8) begin : g_wide
            assign addr_in = ADDR_W'(byte_data);
        end else begin : g_narrow
            assign addr_in = byte_data[ADDR_W-1:0];
        end
    endgenerate

    cmd_guard_ctrl_decode u_dec (
        .ctrl_byte (byte_data),
        .strap_cs  (strap_cs),
        .busy      (prog_busy),
        .hw_wp     (hw_wp),
        .locked    (locked),
        .verdict   (verdict)
    );

    cmd_guard_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (addr_in),
        .step     (ptr_step),
        .ptr      (ptr)
    );

    cmd_guard_lock_flag u_lock (
        .clk     (clk),
        .commit  (commit),
        .preload (lock_preload),
        .locked  (locked)
    );

    cmd_guard_wr_gate u_gate (
        .addr_msb (ptr[ADDR_W-1]),
        .hw_wp    (hw_wp),
        .locked   (locked),
        .allow    (allow_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            txn_q       <= TXN_NONE;
            resp_vld_q  <= 1'b0;
            resp_ack_q  <= 1'b0;
            wr_req_q    <= 1'b0;
            wr_allow_q  <= 1'b0;
            wr_addr_q   <= '0;
            lock_data_q <= 1'b0;
        end else begin
            resp_vld_q <= 1'b0;
            resp_ack_q <= 1'b0;
            wr_req_q   <= 1'b0;
            wr_allow_q <= 1'b0;
            if (start_seen) begin
                phase_q     <= PH_CTRL;
                txn_q       <= TXN_NONE;
                lock_data_q <= 1'b0;
            end else if (stop_seen) begin
                phase_q     <= PH_IDLE;
                txn_q       <= TXN_NONE;
                lock_data_q <= 1'b0;
            end else if (byte_vld) begin
                resp_vld_q <= 1'b1;
                unique case (phase_q)
                    PH_CTRL: begin
                        resp_ack_q <= verdict.ack;
                        txn_q      <= verdict.txn;
                        if (!verdict.ack || verdict.txn == TXN_ARR_RD)
                            phase_q <= PH_SKIP;
                        else
                            phase_q <= PH_WADDR;
                    end
                    PH_WADDR: begin
                        resp_ack_q <= 1'b1;
                        phase_q    <= PH_DATA;
                    end
                    PH_DATA: begin
                        resp_ack_q <= 1'b1;
                        if (txn_q == TXN_ARR_WR) begin
                            wr_req_q   <= 1'b1;
                            wr_allow_q <= allow_now;
                            wr_addr_q  <= ptr;
                        end else begin
                            lock_data_q <= 1'b1;
                        end
                    end
                    default: resp_ack_q <= 1'b0;
                endcase
            end
        end
    end

    assign resp_vld    = resp_vld_q;
    assign resp_ack    = resp_ack_q;
    assign txn_type    = txn_q;
    assign wr_req      = wr_req_q;
    assign wr_allow    = wr_allow_q;
    assign wr_addr     = wr_addr_q;
    assign prot_status = {hw_wp, locked};
endmodule

// File: rtl/cmd_guard_checker.sv
module cmd_guard_checker (
    input logic       clk,
    input logic       rst,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       prog_busy,
    input logic [2:0] strap_cs,
    input logic       hw_wp,
    input logic       lock_preload,
    input logic       resp_vld,
    input logic       resp_ack,
    input logic       wr_req,
    input logic       wr_allow,
    input logic [1:0] prot_status
);
    logic expect_ctrl;
    logic ctrl_byte;

    always_ff @(posedge clk) begin
        if (rst)                        expect_ctrl <= 1'b0;
        else if (start_seen)            expect_ctrl <= 1'b1;
        else if (stop_seen || byte_vld) expect_ctrl <= 1'b0;
    end

    assign ctrl_byte = expect_ctrl && byte_vld && !start_seen && !stop_seen;

    a_r2_cs_mismatch_nack: assert property (@(posedge clk) disable iff (rst)
        (ctrl_byte && byte_data[3:1] != strap_cs) |=> !resp_ack);

    a_r3_busy_nack: assert property (@(posedge clk) disable iff (rst)
        (ctrl_byte && prog_busy) |=> !resp_ack);

    a_r4_lock_read_nack: assert property (@(posedge clk) disable iff (rst)
        (ctrl_byte && byte_data[7:4] == 4'b0110 && byte_data[0]) |=> !resp_ack);

    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        prot_status[0] |=> prot_status[0]);

    a_r7_lock_needs_pin_low: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_status[0]) |-> (!$past(hw_wp) || $past(lock_preload)));

    a_r9_pin_blocks_store: assert property (@(posedge clk) disable iff (rst)
        (wr_req && $past(hw_wp)) |-> !wr_allow);

    a_r8_store_is_acked: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (resp_vld && resp_ack));

    a_r11_ack_needs_vld: assert property (@(posedge clk) disable iff (rst)
        resp_ack |-> resp_vld);

    a_r11_resp_follows_byte: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !start_seen && !stop_seen) |=> resp_vld);
endmodule

bind cmd_guard_decoder cmd_guard_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_vld     (byte_vld),
    .byte_data    (byte_data),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .prog_busy    (prog_busy),
    .strap_cs     (strap_cs),
    .hw_wp        (hw_wp),
    .lock_preload (lock_preload),
    .resp_vld     (resp_vld),
    .resp_ack     (resp_ack),
    .wr_req       (wr_req),
    .wr_allow     (wr_allow),
    .prot_status  (prot_status)
);

// File: tb/tb_cmd_guard_decoder.sv
`timescale 1ns/1ps
module tb_cmd_guard_decoder;
    localparam int AW = 8;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          start_seen = 1'b0, stop_seen = 1'b0, prog_busy = 1'b0;
    logic [2:0]    strap_cs = 3'b101;
    logic          hw_wp = 1'b0;
    logic          resp_vld, resp_ack, wr_req, wr_allow;
    logic [1:0]    txn_type, prot_status;
    logic [AW-1:0] wr_addr;

    logic          pl_vld, pl_ack, pl_wr, pl_allow;
    logic [1:0]    pl_txn, pl_status;
    logic [AW-1:0] pl_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmd_guard_decoder #(.ADDR_W(AW), .PAGE_W(PW)) dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .start_seen(start_seen), .stop_seen(stop_seen), .prog_busy(prog_busy),
        .strap_cs(strap_cs), .hw_wp(hw_wp), .lock_preload(1'b0),
        .resp_vld(resp_vld), .resp_ack(resp_ack), .txn_type(txn_type),
        .wr_req(wr_req), .wr_allow(wr_allow), .wr_addr(wr_addr),
        .prot_status(prot_status)
    );

    cmd_guard_decoder #(.ADDR_W(AW), .PAGE_W(PW)) dut_pl (
        .clk(clk), .rst(rst), .byte_vld(1'b0), .byte_data(8'h00),
        .start_seen(1'b0), .stop_seen(1'b0), .prog_busy(1'b0),
        .strap_cs(3'b000), .hw_wp(1'b0), .lock_preload(1'b1),
        .resp_vld(pl_vld), .resp_ack(pl_ack), .txn_type(pl_txn),
        .wr_req(pl_wr), .wr_allow(pl_allow), .wr_addr(pl_addr),
        .prot_status(pl_status)
    );

    typedef struct {
        logic          ack;
        logic          wr;
        logic          allow;
        logic [AW-1:0] addr;
        logic [1:0]    txn;
        string         tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per response pulse.
    always @(negedge clk) begin
        if (resp_vld) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(resp_ack == e.ack, {e.tag, " ack"}, resp_ack, e.ack);
                chk(txn_type == e.txn, {e.tag, " txn"}, txn_type, e.txn);
                chk(wr_req == e.wr, {e.tag, " wr_req"}, wr_req, e.wr);
                if (e.wr) begin
                    chk(wr_allow == e.allow, {e.tag, " allow"}, wr_allow, e.allow);
                    chk(wr_addr == e.addr, {e.tag, " addr"}, wr_addr, e.addr);
                end
            end
        end
    end

    task automatic put_byte(input logic [7:0] d, input logic ack, input logic [1:0] txn,
                            input logic wr, input logic allow, input logic [AW-1:0] addr,
                            input string tag);
        exp_t e;
        e.ack = ack; e.txn = txn; e.wr = wr; e.allow = allow; e.addr = addr; e.tag = tag;
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = d;
        sb.push_back(e);
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic bus_start();
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(resp_vld == 0 && wr_req == 0, "R10 reset outputs", {resp_vld, wr_req}, 0);
        chk(txn_type == 0, "R10 reset txn", txn_type, 0);
        chk(prot_status == 0, "R10 reset status", prot_status, 0);

        put_byte(8'hAA, 0, 0, 0, 0, 0, "R10 byte before START");

        // Array write with page wrap (4-byte page)
        bus_start();
        put_byte(8'hAA, 1, 1, 0, 0, 0, "R1 write ctrl");
        put_byte(8'h85, 1, 1, 0, 0, 0, "R8 word addr");
        put_byte(8'h11, 1, 1, 1, 1, 8'h85, "R8 data0");
        put_byte(8'h22, 1, 1, 1, 1, 8'h86, "R8 data1");
        put_byte(8'h33, 1, 1, 1, 1, 8'h87, "R8 data2");
        put_byte(8'h44, 1, 1, 1, 1, 8'h84, "R8 wrap");
        put_byte(8'h55, 1, 1, 1, 1, 8'h85, "R8 after wrap");
        bus_stop();

        bus_start();
        put_byte(8'hAB, 1, 2, 0, 0, 0, "R1 read ctrl");
        put_byte(8'h00, 0, 2, 0, 0, 0, "R10 byte in read");
        bus_stop();

        bus_start();
        put_byte(8'hA8, 0, 0, 0, 0, 0, "R2 cs mismatch");
        put_byte(8'h12, 0, 0, 0, 0, 0, "R10 byte after nack");
        bus_stop();
        bus_start();
        put_byte(8'hFA, 0, 0, 0, 0, 0, "R2 unknown code");
        bus_stop();

        prog_busy = 1'b1;
        bus_start();
        put_byte(8'hAA, 0, 0, 0, 0, 0, "R3 busy array");
        bus_stop();
        bus_start();
        put_byte(8'h6A, 0, 0, 0, 0, 0, "R3 busy lock");
        bus_stop();
        prog_busy = 1'b0;

        bus_start();
        put_byte(8'h6B, 0, 0, 0, 0, 0, "R4 lock read");
        bus_stop();

        bus_start();
        put_byte(8'h6A, 1, 3, 0, 0, 0, "R5 lock ctrl");
        put_byte(8'h33, 1, 3, 0, 0, 0, "R5 lock addr");
        bus_stop();
        chk(prot_status == 2'b00, "R5 incomplete no lock", prot_status, 0);

        hw_wp = 1'b1;
        @(negedge clk);
        chk(prot_status == 2'b10, "R7 status pin", prot_status, 2);
        bus_start();
        put_byte(8'hAA, 1, 1, 0, 0, 0, "R9 ctrl pin high");
        put_byte(8'h90, 1, 1, 0, 0, 0, "R9 addr pin high");
        put_byte(8'h5A, 1, 1, 1, 0, 8'h90, "R9 pin blocks");
        bus_stop();
        bus_start();
        put_byte(8'h6A, 0, 0, 0, 0, 0, "R7 lock nack pin");
        put_byte(8'h00, 0, 0, 0, 0, 0, "R7 following byte");
        bus_stop();
        chk(prot_status == 2'b10, "R7 lock not set", prot_status, 2);
        hw_wp = 1'b0;

        bus_start();
        put_byte(8'h6A, 1, 3, 0, 0, 0, "R5 lock ctrl");
        put_byte(8'hC3, 1, 3, 0, 0, 0, "R5 ignored addr");
        put_byte(8'h3C, 1, 3, 0, 0, 0, "R5 ignored data");
        bus_stop();
        chk(prot_status == 2'b01, "R5 lock set on stop", prot_status, 1);

        bus_start();
        put_byte(8'h6A, 0, 0, 0, 0, 0, "R6 lock ctrl after set");
        bus_stop();

        bus_start();
        put_byte(8'hAA, 1, 1, 0, 0, 0, "R9 ctrl");
        put_byte(8'h7E, 1, 1, 0, 0, 0, "R9 addr");
        put_byte(8'h01, 1, 1, 1, 0, 8'h7E, "R9 low half 7E");
        put_byte(8'h02, 1, 1, 1, 0, 8'h7F, "R9 low half 7F");
        bus_stop();
        bus_start();
        put_byte(8'hAA, 1, 1, 0, 0, 0, "R9 ctrl");
        put_byte(8'h80, 1, 1, 0, 0, 0, "R9 addr");
        put_byte(8'h03, 1, 1, 1, 1, 8'h80, "R9 upper half");
        bus_stop();

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(prot_status[0] == 1'b1, "R6 lock survives reset", prot_status[0], 1);
        chk(pl_status == 2'b01, "R6 preload sets lock", pl_status, 1);
        chk(sb.size() == 0, "R11 all responses seen", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule